// File: doc/BRIEF.md
# Processor Clock Domain Wake-Up Controller

This block decides when the clock of a processor domain, and of each of its subdomains, may run. When the domain is asked to go idle it drops its clock enable and holds it low. It raises the enable again only on a qualifying wake event: a system reset, a processor-domain reset request, or an interrupt that is not masked. The clock-enable outputs drive a downstream clock gate. Every one of them comes straight from a flop, so the gate never sees a combinational glitch.

Whether an interrupt may wake the domain depends on the chip state. If the chip is running, or the wake-mode bit is set, any unmasked interrupt is enough. If the chip is idle and the wake-mode bit is clear, external wake control takes over. In that case the active-low external wake pin must also be low. The pin is synchronized before it is used. Each subdomain keeps its own idle flag. Software reloads these flags with an idle command, and on an interrupt wake a subdomain returns only if its restart-enable bit is set. A one-cycle flag marks each idle-to-running transition of the domain.

Top module: `dsp_wake_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, `dom_clk_en` is 1, every bit of `sub_clk_en` is 1, `wake_pulse` is 0, and all subdomain idle flags are clear.
- R2: A cycle with `dsp_rst_req`=1 makes `dom_clk_en` and every bit of `sub_clk_en` 1 from the next cycle on, and clears every subdomain idle flag, whatever the other inputs are.
- R3: While the domain runs, `dom_idle_req`=1 with no wake condition present stops the domain. From the next cycle on, `dom_clk_en` is 0 and `sub_clk_en` is all zeros.
- R4: While the domain is stopped, an interrupt `irq_req[i]`=1 with `irq_mask[i]`=0, together with `wake_mode`=1 or `chip_idle`=0, sets `dom_clk_en` to 1 in the next cycle.
- R5: An interrupt whose mask bit is 1 never wakes the stopped domain, in any mode.
- R6: While the domain is stopped with `chip_idle`=1 and `wake_mode`=0, an unmasked interrupt wakes it only while the synchronized `ext_wake_n` is low. After `ext_wake_n` falls before a clock edge, the domain is running after the third edge and not before.
- R7: `wake_pulse` is 1 for exactly one cycle. It is the first cycle in which `dom_clk_en` is 1 after having been 0, whether the wake came from an interrupt or from `dsp_rst_req`.
- R8: On an interrupt wake, a subdomain whose idle flag is set restarts only if its bit in `sub_restart_en` is 1, and that restart clears its flag. If the bit is 0, its `sub_clk_en` bit stays 0. Subdomains with a clear flag restart.
- R9: `idle_cmd`=1 while the domain runs loads each idle flag from `sub_idle_req[i]` (1 means idle). In the next cycle `sub_clk_en[i]` equals the inverse of that bit.
- R10: `idle_cmd` while the domain is stopped leaves the idle flags unchanged. This is seen through `sub_clk_en` after the next wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| dsp_rst_req | input | 1 | Domain reset request, synchronous, active high |
| irq_req | input | N_IRQ | Interrupt request lines |
| irq_mask | input | N_IRQ | Interrupt mask, 1 = masked |
| wake_mode | input | 1 | 1 = any unmasked interrupt wakes, even when the chip is idle |
| chip_idle | input | 1 | Chip-level idle status |
| ext_wake_n | input | 1 | External wake pin, active low, asynchronous |
| dom_idle_req | input | 1 | Request to stop the domain clock |
| idle_cmd | input | 1 | Idle command pulse that reloads the subdomain idle flags |
| sub_idle_req | input | N_SUB | Per-subdomain idle configuration, 1 = idle |
| sub_restart_en | input | N_SUB | Per-subdomain restart enable on interrupt wake |
| dom_clk_en | output | 1 | Registered domain clock enable |
| sub_clk_en | output | N_SUB | Registered subdomain clock enables |
| wake_pulse | output | 1 | One-cycle idle-to-running marker |

## Verification
The assertions assume several things about the inputs. All control inputs except `ext_wake_n` are synchronous to `clk`. `idle_cmd` is a single-cycle strobe. `ext_wake_n` may change at any time, because it is only ever used after synchronization. The stimulus drives every input on the falling edge. It puts the domain to sleep only while no unmasked interrupt is pending, so the idle request is not blocked by a wake condition. It holds the external pin stable for several cycles around each interrupt, so the three-edge latency of R6 can be observed exactly.

// File: rtl/dwc_pkg.sv
package dwc_pkg;

   // Domain run state; the encoding doubles as the clock-enable value
   typedef enum logic {
      DOM_STOP = 1'b0,
      DOM_RUN  = 1'b1
   } dom_state_e;

   // Selects how an unmasked interrupt is qualified
   typedef enum logic {
      WAKE_DIRECT   = 1'b0,   // interrupt alone always wakes
      WAKE_EXTGATED = 1'b1    // idle chip with wake_mode=0 needs the external pin
   } wake_variant_e;

endpackage

// File: rtl/dwc_sync.sv
module dwc_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dwc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RESET_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/dwc_wake_eval.sv
module dwc_wake_eval
   import dwc_pkg::*;
#(
   parameter int            N_IRQ   = 8,
   parameter wake_variant_e VARIANT = WAKE_EXTGATED
) (
   input  logic [N_IRQ-1:0] irq_req_i,
   input  logic [N_IRQ-1:0] irq_mask_i,
   input  logic             wake_mode_i,
   input  logic             chip_idle_i,
   input  logic             ext_wake_sync_n_i,
   output logic             irq_pending_o,
   output logic             irq_wake_o
);

   if (N_IRQ < 1) begin : g_bad_irq
      $error("dwc_wake_eval: N_IRQ must be at least 1");
   end

   logic [N_IRQ-1:0] live_irq;

   assign live_irq      = irq_req_i & ~irq_mask_i;
   assign irq_pending_o = |live_irq;

   if (VARIANT == WAKE_EXTGATED) begin : g_extgated
      logic ext_gate_open;
      // The external pin only matters when the chip idles with wake_mode clear
      assign ext_gate_open = wake_mode_i | ~chip_idle_i | ~ext_wake_sync_n_i;
      assign irq_wake_o    = irq_pending_o & ext_gate_open;
   end else begin : g_direct
      logic unused_cfg;
      assign unused_cfg = wake_mode_i ^ chip_idle_i ^ ext_wake_sync_n_i;
      assign irq_wake_o = irq_pending_o;
   end

endmodule

// File: rtl/dwc_sub_gate.sv
module dwc_sub_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic dsp_rst_i,
   input  logic dom_run_i,
   input  logic next_run_i,
   input  logic wake_i,
   input  logic idle_cmd_i,
   input  logic idle_req_i,
   input  logic restart_en_i,
   output logic clk_en_o
);

   logic flag_q;
   logic flag_d;
   logic en_q;

   always_comb begin
      flag_d = flag_q;
      if (dsp_rst_i) begin
         flag_d = 1'b0;
      end else if (dom_run_i && idle_cmd_i) begin
         flag_d = idle_req_i;
      end else if (wake_i && restart_en_i) begin
         flag_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         en_q   <= 1'b1;
      end else begin
         flag_q <= flag_d;
         en_q   <= next_run_i & ~flag_d;
      end
   end

   assign clk_en_o = en_q;

   // R8: a flagged subdomain without restart enable stays off across a wake
   assert_sub_hold_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (!dom_run_i && wake_i && !dsp_rst_i && flag_q && !restart_en_i) |=> !clk_en_o);

   // R9: idle command while running reloads the enable from the request
   assert_idle_reload_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (dom_run_i && idle_cmd_i && !dsp_rst_i && next_run_i)
         |=> (clk_en_o == !$past(idle_req_i)));

   // R2: domain reset always reopens this subdomain
   assert_sub_reset_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      dsp_rst_i |=> clk_en_o);

endmodule

// File: rtl/dsp_wake_ctrl.sv
module dsp_wake_ctrl
   import dwc_pkg::*;
#(
   parameter int            N_IRQ       = 8,
   parameter int            N_SUB       = 4,
   parameter int            SYNC_STAGES = 2,
   parameter wake_variant_e VARIANT     = WAKE_EXTGATED
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dsp_rst_req,
   input  logic [N_IRQ-1:0] irq_req,
   input  logic [N_IRQ-1:0] irq_mask,
   input  logic             wake_mode,
   input  logic             chip_idle,
   input  logic             ext_wake_n,
   input  logic             dom_idle_req,
   input  logic             idle_cmd,
   input  logic [N_SUB-1:0] sub_idle_req,
   input  logic [N_SUB-1:0] sub_restart_en,
   output logic             dom_clk_en,
   output logic [N_SUB-1:0] sub_clk_en,
   output logic             wake_pulse
);

   if (N_SUB < 1) begin : g_bad_sub
      $error("dsp_wake_ctrl: N_SUB must be at least 1");
   end

   dom_state_e dom_q;
   dom_state_e dom_d;
   logic       pulse_q;
   logic       ext_sync_n;
   logic       irq_pending;
   logic       irq_wake;
   logic       dom_run;
   logic       next_run;
   logic       irq_wakes_now;

   dwc_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_ext_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (ext_wake_n),
      .q_o   (ext_sync_n)
   );

   dwc_wake_eval #(
      .N_IRQ   (N_IRQ),
      .VARIANT (VARIANT)
   ) u_wake_eval (
      .irq_req_i         (irq_req),
      .irq_mask_i        (irq_mask),
      .wake_mode_i       (wake_mode),
      .chip_idle_i       (chip_idle),
      .ext_wake_sync_n_i (ext_sync_n),
      .irq_pending_o     (irq_pending),
      .irq_wake_o        (irq_wake)
   );

   assign dom_run       = (dom_q == DOM_RUN);
   assign irq_wakes_now = !dom_run && irq_wake && !dsp_rst_req;

   always_comb begin
      dom_d = dom_q;
      if (dsp_rst_req) begin
         dom_d = DOM_RUN;
      end else if (!dom_run && irq_wake) begin
         dom_d = DOM_RUN;
      end else if (dom_run && dom_idle_req && !irq_wake) begin
         dom_d = DOM_STOP;
      end
   end

   assign next_run = (dom_d == DOM_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dom_q   <= DOM_RUN;
         pulse_q <= 1'b0;
      end else begin
         dom_q   <= dom_d;
         pulse_q <= !dom_run && next_run;
      end
   end

   for (genvar s = 0; s < N_SUB; s++) begin : g_sub
      dwc_sub_gate u_gate (
         .clk          (clk),
         .rst_n        (rst_n),
         .dsp_rst_i    (dsp_rst_req),
         .dom_run_i    (dom_run),
         .next_run_i   (next_run),
         .wake_i       (irq_wakes_now),
         .idle_cmd_i   (idle_cmd),
         .idle_req_i   (sub_idle_req[s]),
         .restart_en_i (sub_restart_en[s]),
         .clk_en_o     (sub_clk_en[s])
      );
   end

   assign dom_clk_en = dom_run;
   assign wake_pulse = pulse_q;

   // R2: domain reset restarts the domain
   assert_dsp_reset_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      dsp_rst_req |=> dom_clk_en);

   // R4: unmasked interrupt with an open gate wakes the domain
   assert_irq_wake_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (!dom_clk_en && !dsp_rst_req && ((irq_req & ~irq_mask) != '0)
         && (wake_mode || !chip_idle)) |=> dom_clk_en);

   // R5: masked interrupts never wake
   assert_masked_quiet_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (!dom_clk_en && !dsp_rst_req && ((irq_req & ~irq_mask) == '0)) |=> !dom_clk_en);

   // R6: idle chip with wake_mode clear needs the synchronized pin low
   if (VARIANT == WAKE_EXTGATED) begin : g_ext_chk
      assert_ext_gate_R6 : assert property (@(posedge clk) disable iff (!rst_n)
         (!dom_clk_en && !dsp_rst_req && chip_idle && !wake_mode && ext_sync_n)
            |=> !dom_clk_en);
   end

   // R3: stopped domain has every subdomain off
   assert_stop_subs_off_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      !dom_clk_en |-> (sub_clk_en == '0));

   // R7: pulse marks the first running cycle only
   assert_pulse_edge_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> (dom_clk_en && !$past(dom_clk_en)));

   assert_pulse_single_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);

endmodule

// File: tb/tb_dsp_wake_ctrl.sv
module tb_dsp_wake_ctrl;

   localparam int N_IRQ = 8;
   localparam int N_SUB = 4;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             dsp_rst_req;
   logic [N_IRQ-1:0] irq_req;
   logic [N_IRQ-1:0] irq_mask;
   logic             wake_mode;
   logic             chip_idle;
   logic             ext_wake_n;
   logic             dom_idle_req;
   logic             idle_cmd;
   logic [N_SUB-1:0] sub_idle_req;
   logic [N_SUB-1:0] sub_restart_en;
   logic             dom_clk_en;
   logic [N_SUB-1:0] sub_clk_en;
   logic             wake_pulse;

   int vectors  = 0;
   int failures = 0;

   always #5 clk = ~clk;

   dsp_wake_ctrl #(.N_IRQ(N_IRQ), .N_SUB(N_SUB)) dut (
      .clk(clk), .rst_n(rst_n), .dsp_rst_req(dsp_rst_req),
      .irq_req(irq_req), .irq_mask(irq_mask), .wake_mode(wake_mode),
      .chip_idle(chip_idle), .ext_wake_n(ext_wake_n),
      .dom_idle_req(dom_idle_req), .idle_cmd(idle_cmd),
      .sub_idle_req(sub_idle_req), .sub_restart_en(sub_restart_en),
      .dom_clk_en(dom_clk_en), .sub_clk_en(sub_clk_en), .wake_pulse(wake_pulse)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic quiet();
      dsp_rst_req = 0; irq_req = '0; irq_mask = '0; wake_mode = 0;
      chip_idle = 0; ext_wake_n = 1; dom_idle_req = 0; idle_cmd = 0;
      sub_idle_req = '0; sub_restart_en = '0;
   endtask

   task automatic go_idle();
      dom_idle_req = 1; step(); dom_idle_req = 0;
   endtask

   task automatic t_reset();
      quiet(); rst_n = 0;
      step(); step();
      chk("R1 dom_clk_en in reset", 32'(dom_clk_en), 1);
      chk("R1 sub_clk_en in reset", 32'(sub_clk_en), 32'hF);
      rst_n = 1; step();
      chk("R1 wake_pulse after reset", 32'(wake_pulse), 0);
      chk("R1 sub_clk_en after reset", 32'(sub_clk_en), 32'hF);
   endtask

   task automatic t_idle_then_mode_wake();
      quiet(); go_idle();
      chk("R3 dom stopped", 32'(dom_clk_en), 0);
      chk("R3 subs stopped", 32'(sub_clk_en), 0);
      chk("R7 no pulse on stop", 32'(wake_pulse), 0);
      irq_req = 8'h04; wake_mode = 1; chip_idle = 1; step();
      chk("R4 wake via wake_mode", 32'(dom_clk_en), 1);
      chk("R7 pulse on wake", 32'(wake_pulse), 1);
      chk("R8 clear flags restart", 32'(sub_clk_en), 32'hF);
      irq_req = '0; step();
      chk("R7 pulse one cycle", 32'(wake_pulse), 0);
      quiet(); go_idle();
      irq_req = 8'h80; chip_idle = 0; step();
      chk("R4 wake chip running", 32'(dom_clk_en), 1);
      quiet(); step();
   endtask

   task automatic t_masked();
      quiet(); go_idle();
      irq_req = 8'h09; irq_mask = 8'h09; wake_mode = 1;
      for (int k = 0; k < 3; k++) begin
         step();
         chk("R5 masked irq no wake", 32'(dom_clk_en), 0);
      end
      chip_idle = 1; wake_mode = 0; ext_wake_n = 0;
      step(); step(); step();
      chk("R5 masked irq with pin low", 32'(dom_clk_en), 0);
      irq_mask = 8'h08; step();
      chk("R4 unmask wakes", 32'(dom_clk_en), 1);
      quiet(); step(); step(); step();
   endtask

   task automatic t_ext_wake();
      quiet(); go_idle();
      chip_idle = 1; wake_mode = 0; irq_req = 8'h01;
      step(); step(); step();
      chk("R6 irq alone blocked", 32'(dom_clk_en), 0);
      ext_wake_n = 0;
      step();
      chk("R6 edge1 still stopped", 32'(dom_clk_en), 0);
      step();
      chk("R6 edge2 still stopped", 32'(dom_clk_en), 0);
      step();
      chk("R6 edge3 running", 32'(dom_clk_en), 1);
      chk("R7 pulse on ext wake", 32'(wake_pulse), 1);
      quiet(); step(); step(); step();
   endtask

   task automatic t_sub_restart();
      quiet();
      idle_cmd = 1; sub_idle_req = 4'b0110; step(); idle_cmd = 0;
      chk("R9 reload flags", 32'(sub_clk_en), 32'b1001);
      go_idle();
      chk("R3 subs off", 32'(sub_clk_en), 0);
      sub_restart_en = 4'b0100; irq_req = 8'h02; wake_mode = 1; step();
      chk("R8 selective restart", 32'(sub_clk_en), 32'b1101);
      quiet();
      idle_cmd = 1; sub_idle_req = 4'b0000; step(); idle_cmd = 0;
      chk("R9 reload clears", 32'(sub_clk_en), 32'hF);
   endtask

   task automatic t_cmd_while_stopped();
      quiet(); go_idle();
      idle_cmd = 1; sub_idle_req = 4'b1111; step(); idle_cmd = 0;
      chk("R10 still stopped", 32'(dom_clk_en), 0);
      irq_req = 8'h10; wake_mode = 1; step();
      chk("R10 flags untouched", 32'(sub_clk_en), 32'hF);
      quiet(); step();
   endtask

   task automatic t_dsp_reset();
      quiet();
      idle_cmd = 1; sub_idle_req = 4'b1010; step(); idle_cmd = 0;
      chk("R9 flags set", 32'(sub_clk_en), 32'b0101);
      go_idle();
      dsp_rst_req = 1; irq_mask = '1; step(); dsp_rst_req = 0;
      chk("R2 dom restarted", 32'(dom_clk_en), 1);
      chk("R2 subs restarted", 32'(sub_clk_en), 32'hF);
      chk("R7 pulse on reset wake", 32'(wake_pulse), 1);
      step();
      chk("R7 pulse cleared", 32'(wake_pulse), 0);
      idle_cmd = 1; sub_idle_req = 4'b0011; step(); idle_cmd = 0;
      dsp_rst_req = 1; step(); dsp_rst_req = 0;
      chk("R2 reset while running", 32'(sub_clk_en), 32'hF);
      chk("R7 no pulse when running", 32'(wake_pulse), 0);
      quiet(); step();
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      report();
   end

   initial begin
      quiet(); rst_n = 0;
      t_reset();
      t_idle_then_mode_wake();
      t_masked();
      t_ext_wake();
      t_sub_restart();
      t_cmd_while_stopped();
      t_dsp_reset();
      report();
   end

endmodule